// File: doc/BRIEF.md
# LED Output Mode Selector

This block decides, for each of seven open-drain LED pins, what drives the pin. Three 8-bit select registers each give one bit to every pin. Bit n of the third, second and first register, read in that order, forms a 3-bit mode code for pin n. The code chooses one of these drives: released (LED off), pulled low steadily, a steady level taken from bank 0 or bank 1, a steady level at the master intensity, or the live blinking waveform of bank 0 or bank 1. A steady level L from 0 to 15 is made by pulling the pin low for the first L of the 15 slots in a shared frame.

Each bank's peak brightness is either that bank's own nibble from the peak-level input or the master level. An override bit per bank makes the choice. The blink waveform generators and the serial register interface are outside this block. Their results come in as inputs: a register write strobe, the bank waveforms, and a one-shot completion pulse per bank that carries the bank's final state. When a one-shot completes, the block rewrites the select bits of every pin that follows that bank's waveform. Those pins then either stay steady at the bank peak or turn off. Software can read the select registers back through dedicated outputs.

Top module: `led_mode_sel`

## Requirements
- R1: Pin n (0..6) takes its mode code from bit n of the three select registers, as {sel2, sel1, sel0}. A write with regWrSel 0, 1 or 2 loads sel0, sel1 or sel2, and regWrSel 3 is ignored. Bit 7 of each select register always reads 0.
- R2: Codes 000 and 001 release the pin (ledSink = 0) in every cycle.
- R3: Code 100 pulls the pin low in every cycle (ledSink = 1). With sel1 and sel0 cleared, the pin therefore acts as a general-purpose output that shows the inverse of its sel2 bit.
- R4: Code 010 gives a steady level equal to bank 0's peak, and code 011 gives a steady level equal to bank 1's peak. Bank 0's own peak is peakLevels[3:0] and bank 1's is peakLevels[7:4].
- R5: mstrCfg[4] set makes bank 0's peak equal to the master level mstrCfg[3:0]. mstrCfg[5] does the same for bank 1. A clear bit keeps the bank's own nibble.
- R6: Code 101 gives a steady level equal to the master level mstrCfg[3:0]. Level 0 never pulls low, and level 15 always pulls low.
- R7: Codes 110 and 111 copy bankWave[0] and bankWave[1] to the pin, one clock later.
- R8: A shotDone[b] pulse changes every pin whose code is 11b. If shotFinalOn[b] is 1, the pin's sel2 is cleared and sel1 is set, giving code 01b. If shotFinalOn[b] is 0, both sel2 and sel1 are cleared, giving code 00b. The sel0 bit and all other pins keep their values.
- R9: When a register write and a one-shot completion fall in the same cycle, the written register takes the written data. The rewrite still applies to the registers that were not written.
- R10: After reset all select bits are 0 and every pin is released.
- R11: A frame is 15 slots of SLOT_CLKS clocks each. A steady level L pulls the pin low for exactly L*SLOT_CLKS clocks of every frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| regWrEn | input | 1 | Select register write strobe |
| regWrSel | input | 2 | Register index: 0, 1 or 2; 3 is ignored |
| regWrData | input | 7 | Write data, one bit per pin |
| peakLevels | input | 8 | Bank peak levels, bank 1 in [7:4] and bank 0 in [3:0] |
| mstrCfg | input | 6 | [3:0] master level, [4] bank 0 override, [5] bank 1 override |
| bankWave | input | 2 | Live blink waveform per bank, 1 = pull low |
| shotDone | input | 2 | One-shot completion pulse per bank |
| shotFinalOn | input | 2 | Final state of a completed one-shot per bank, 1 = on at peak |
| ledSink | output | 7 | Per-pin sink enable, 1 = pull low and 0 = release |
| selQ0 | output | 8 | Select register 0 readback |
| selQ1 | output | 8 | Select register 1 readback |
| selQ2 | output | 8 | Select register 2 readback |

## Verification
A corrupted select bit shows up on the readback outputs in the next cycle. It also changes the drive of that pin one clock later. A rewrite that lands on the wrong pins or clears the wrong bit appears as soon as the select registers are read after the completion pulse. A fault in the frame counter or the level comparison is silent in any single cycle. It only shows when the low-time of a pin is counted over a whole frame, so duty is checked at both ends of the range and at several levels in between. Peak-source errors appear only when a bank's own nibble and the master level differ, so those tests set them to different values.

// File: rtl/led_sel_pkg.sv
package led_sel_pkg;
  localparam int LVL_W = 4;
  localparam int REG_W = 8;
  localparam int BANKS = 2;

  typedef enum logic [2:0] {
    MODE_OFF_A  = 3'b000,
    MODE_OFF_B  = 3'b001,
    MODE_PEAK0  = 3'b010,
    MODE_PEAK1  = 3'b011,
    MODE_SINK   = 3'b100,
    MODE_MASTER = 3'b101,
    MODE_WAVE0  = 3'b110,
    MODE_WAVE1  = 3'b111
  } ledMode_e;

  typedef struct packed {
    logic [2:0]       wrSel;
    logic [BANKS-1:0] shotOn;
    logic [BANKS-1:0] shotOff;
    logic [LVL_W-1:0] slot;
  } selStrobe_t;
endpackage

// File: rtl/led_sel_ctrl.sv
module led_sel_ctrl
  import led_sel_pkg::*;
#(
  parameter int SLOT_CLKS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             regWrEn,
  input  logic [1:0]       regWrSel,
  input  logic [BANKS-1:0] shotDone,
  input  logic [BANKS-1:0] shotFinalOn,
  output selStrobe_t       strb
);
  localparam int LEVELS = (1 << LVL_W) - 1;
  localparam int PW     = (SLOT_CLKS > 1) ? $clog2(SLOT_CLKS) : 1;

  logic [PW-1:0]    preCnt;
  logic [LVL_W-1:0] slotCnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      preCnt  <= '0;
      slotCnt <= '0;
    end else if (preCnt == PW'(SLOT_CLKS - 1)) begin
      preCnt  <= '0;
      slotCnt <= (slotCnt == LVL_W'(LEVELS - 1)) ? '0 : slotCnt + 1'b1;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  always_comb begin
    strb.wrSel = 3'b000;
    if (regWrEn) begin
      case (regWrSel)
        2'd0:    strb.wrSel = 3'b001;
        2'd1:    strb.wrSel = 3'b010;
        2'd2:    strb.wrSel = 3'b100;
        default: strb.wrSel = 3'b000;
      endcase
    end
    strb.shotOn  = shotDone & shotFinalOn;
    strb.shotOff = shotDone & ~shotFinalOn;
    strb.slot    = slotCnt;
  end
endmodule

// File: rtl/led_sel_dp.sv
module led_sel_dp
  import led_sel_pkg::*;
#(
  parameter int NUM_OUT = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  selStrobe_t         strb,
  input  logic [NUM_OUT-1:0] wrData,
  input  logic [7:0]         peakLevels,
  input  logic [5:0]         mstrCfg,
  input  logic [BANKS-1:0]   bankWave,
  output logic [NUM_OUT-1:0] sinkQ,
  output logic [REG_W-1:0]   sel0Q,
  output logic [REG_W-1:0]   sel1Q,
  output logic [REG_W-1:0]   sel2Q
);
  logic [NUM_OUT-1:0] s0, s1, s2;
  logic [NUM_OUT-1:0] n0, n1, n2;
  logic [NUM_OUT-1:0] sinkNext;
  logic [LVL_W-1:0]   peak0, peak1, mstrLvl;
  logic               on0, on1, onM;

  assign mstrLvl = mstrCfg[3:0];
  assign peak0   = mstrCfg[4] ? mstrLvl : peakLevels[3:0];
  assign peak1   = mstrCfg[5] ? mstrLvl : peakLevels[7:4];
  assign on0     = strb.slot < peak0;
  assign on1     = strb.slot < peak1;
  assign onM     = strb.slot < mstrLvl;

  always_comb begin
    n0 = s0;
    n1 = s1;
    n2 = s2;
    for (int i = 0; i < NUM_OUT; i++) begin
      if (s2[i] && s1[i]) begin
        if (strb.shotOn[s0[i]]) begin
          n2[i] = 1'b0;
          n1[i] = 1'b1;
        end else if (strb.shotOff[s0[i]]) begin
          n2[i] = 1'b0;
          n1[i] = 1'b0;
        end
      end
    end
    if (strb.wrSel[0]) n0 = wrData;
    if (strb.wrSel[1]) n1 = wrData;
    if (strb.wrSel[2]) n2 = wrData;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s0 <= '0;
      s1 <= '0;
      s2 <= '0;
    end else begin
      s0 <= n0;
      s1 <= n1;
      s2 <= n2;
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_OUT; i++) begin
      case (ledMode_e'({s2[i], s1[i], s0[i]}))
        MODE_OFF_A, MODE_OFF_B: sinkNext[i] = 1'b0;
        MODE_PEAK0:             sinkNext[i] = on0;
        MODE_PEAK1:             sinkNext[i] = on1;
        MODE_SINK:              sinkNext[i] = 1'b1;
        MODE_MASTER:            sinkNext[i] = onM;
        MODE_WAVE0:             sinkNext[i] = bankWave[0];
        default:                sinkNext[i] = bankWave[1];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sinkQ <= '0;
    else        sinkQ <= sinkNext;
  end

  assign sel0Q = {{(REG_W-NUM_OUT){1'b0}}, s0};
  assign sel1Q = {{(REG_W-NUM_OUT){1'b0}}, s1};
  assign sel2Q = {{(REG_W-NUM_OUT){1'b0}}, s2};
endmodule

// File: rtl/led_mode_sel.sv
module led_mode_sel
  import led_sel_pkg::*;
#(
  parameter int NUM_OUT   = 7,
  parameter int SLOT_CLKS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               regWrEn,
  input  logic [1:0]         regWrSel,
  input  logic [NUM_OUT-1:0] regWrData,
  input  logic [7:0]         peakLevels,
  input  logic [5:0]         mstrCfg,
  input  logic [1:0]         bankWave,
  input  logic [1:0]         shotDone,
  input  logic [1:0]         shotFinalOn,
  output logic [NUM_OUT-1:0] ledSink,
  output logic [REG_W-1:0]   selQ0,
  output logic [REG_W-1:0]   selQ1,
  output logic [REG_W-1:0]   selQ2
);
  selStrobe_t strb;

  led_sel_ctrl #(.SLOT_CLKS(SLOT_CLKS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regWrSel(regWrSel),
    .shotDone(shotDone), .shotFinalOn(shotFinalOn), .strb(strb)
  );

  led_sel_dp #(.NUM_OUT(NUM_OUT)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .wrData(regWrData),
    .peakLevels(peakLevels), .mstrCfg(mstrCfg), .bankWave(bankWave),
    .sinkQ(ledSink), .sel0Q(selQ0), .sel1Q(selQ1), .sel2Q(selQ2)
  );
endmodule

// File: rtl/led_sel_chk.sv
module led_sel_chk #(
  parameter int NUM_OUT = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic               regWrEn,
  input logic [3:0]         mstrLvl,
  input logic [1:0]         bankWave,
  input logic [1:0]         shotDone,
  input logic [1:0]         shotFinalOn,
  input logic [NUM_OUT-1:0] ledSink,
  input logic [7:0]         selQ0,
  input logic [7:0]         selQ1,
  input logic [7:0]         selQ2
);
  // R10
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (selQ0 == 8'h00 && selQ1 == 8'h00 && selQ2 == 8'h00 && ledSink == '0));

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_pin
    // R2
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!selQ2[g] && !selQ1[g]) |=> !ledSink[g]);
    // R3
    steady_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (selQ2[g] && !selQ1[g] && !selQ0[g]) |=> ledSink[g]);
    // R6
    master_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (selQ2[g] && !selQ1[g] && selQ0[g] && mstrLvl == 4'hF) |=> ledSink[g]);
    // R6
    master_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (selQ2[g] && !selQ1[g] && selQ0[g] && mstrLvl == 4'h0) |=> !ledSink[g]);
    // R7
    wave_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (selQ2[g] && selQ1[g]) |=> ledSink[g] == $past(bankWave[selQ0[g]]));
    // R8
    shot_rewrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (selQ2[g] && selQ1[g] && shotDone[selQ0[g]] && !regWrEn)
      |=> (!selQ2[g] && selQ1[g] == $past(shotFinalOn[selQ0[g]]) && selQ0[g] == $past(selQ0[g])));
  end
endmodule

bind led_mode_sel led_sel_chk #(.NUM_OUT(NUM_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .mstrLvl(mstrCfg[3:0]),
  .bankWave(bankWave), .shotDone(shotDone), .shotFinalOn(shotFinalOn),
  .ledSink(ledSink), .selQ0(selQ0), .selQ1(selQ1), .selQ2(selQ2)
);

// File: tb/tb_led_mode_sel.sv
module tb_led_mode_sel;
  localparam int CLK_PERIOD = 10;
  localparam int SLOT_CLKS  = 4;
  localparam int FRAME      = 15 * SLOT_CLKS;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       regWrEn = 1'b0;
  logic [1:0] regWrSel = 2'd0;
  logic [6:0] regWrData = '0;
  logic [7:0] peakLevels = 8'hFF;
  logic [5:0] mstrCfg = 6'h0F;
  logic [1:0] bankWave = 2'b00;
  logic [1:0] shotDone = 2'b00;
  logic [1:0] shotFinalOn = 2'b00;
  logic [6:0] ledSink;
  logic [7:0] selQ0, selQ1, selQ2;

  int  checks = 0;
  int  fails = 0;
  bit  finished = 1'b0;

  led_mode_sel #(.NUM_OUT(7), .SLOT_CLKS(SLOT_CLKS)) dut (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regWrSel(regWrSel),
    .regWrData(regWrData), .peakLevels(peakLevels), .mstrCfg(mstrCfg),
    .bankWave(bankWave), .shotDone(shotDone), .shotFinalOn(shotFinalOn),
    .ledSink(ledSink), .selQ0(selQ0), .selQ1(selQ1), .selQ2(selQ2)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wrReg(input int idx, input logic [6:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regWrSel = 2'(idx); regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic setCodes(input logic [6:0] c2, input logic [6:0] c1, input logic [6:0] c0);
    wrReg(2, c2); wrReg(1, c1); wrReg(0, c0);
    repeat (2) @(negedge clk);
  endtask

  task automatic countLow(input int n, output int c);
    c = 0;
    for (int k = 0; k < FRAME; k++) begin
      @(negedge clk);
      if (ledSink[n]) c++;
    end
  endtask

  task automatic t_reset;
    chk(selQ0 == 0 && selQ1 == 0 && selQ2 == 0, "R10 select regs", {selQ2, selQ1, selQ0}, 0);
    chk(ledSink == 0, "R10 pins released", ledSink, 0);
  endtask

  task automatic t_mapping;
    wrReg(0, 7'h7F);
    @(negedge clk);
    chk(selQ0 == 8'h7F, "R1 bit7 reads zero", selQ0, 8'h7F);
    wrReg(3, 7'h00);
    @(negedge clk);
    chk(selQ0 == 8'h7F && selQ1 == 0 && selQ2 == 0, "R1 index 3 ignored",
        {selQ2, selQ1, selQ0}, 8'h7F);
    setCodes(7'b0001000, 7'h00, 7'h00);
    chk(ledSink == 7'b0001000, "R1 pin 3 from bit 3", ledSink, 7'b0001000);
  endtask

  task automatic t_off;
    int bad = 0;
    setCodes(7'h00, 7'h00, 7'h7F);
    for (int k = 0; k < FRAME; k++) begin
      @(negedge clk);
      if (ledSink != 0) bad++;
    end
    chk(bad == 0, "R2 code 001 released", bad, 0);
    setCodes(7'h00, 7'h00, 7'h00);
    chk(ledSink == 0, "R2 code 000 released", ledSink, 0);
  endtask

  task automatic t_gpio;
    int bad = 0;
    setCodes(7'h55, 7'h00, 7'h00);
    for (int k = 0; k < FRAME; k++) begin
      @(negedge clk);
      if (ledSink != 7'h55) bad++;
    end
    chk(bad == 0, "R3 gpio inverse of sel2", bad, 0);
  endtask

  task automatic t_banks;
    int c;
    peakLevels = 8'hA3; mstrCfg = 6'h05;
    setCodes(7'b0000000, 7'b0000011, 7'b0000010);
    countLow(0, c); chk(c == 3 * SLOT_CLKS, "R4 R11 bank0 level 3", c, 3 * SLOT_CLKS);
    countLow(1, c); chk(c == 10 * SLOT_CLKS, "R4 R11 bank1 level 10", c, 10 * SLOT_CLKS);
    peakLevels = 8'hF0;
    repeat (2) @(negedge clk);
    countLow(0, c); chk(c == 0, "R11 bank0 level 0", c, 0);
    countLow(1, c); chk(c == FRAME, "R11 bank1 level 15", c, FRAME);
  endtask

  task automatic t_override;
    int c;
    peakLevels = 8'h2C; mstrCfg = 6'h17;
    repeat (2) @(negedge clk);
    countLow(0, c); chk(c == 7 * SLOT_CLKS, "R5 bank0 takes master", c, 7 * SLOT_CLKS);
    countLow(1, c); chk(c == 2 * SLOT_CLKS, "R5 bank1 keeps own", c, 2 * SLOT_CLKS);
    mstrCfg = 6'h27;
    repeat (2) @(negedge clk);
    countLow(0, c); chk(c == 12 * SLOT_CLKS, "R5 bank0 keeps own", c, 12 * SLOT_CLKS);
    countLow(1, c); chk(c == 7 * SLOT_CLKS, "R5 bank1 takes master", c, 7 * SLOT_CLKS);
  endtask

  task automatic t_master;
    int c;
    mstrCfg = 6'h09; peakLevels = 8'h11;
    setCodes(7'b0000001, 7'b0000000, 7'b0000001);
    countLow(0, c); chk(c == 9 * SLOT_CLKS, "R6 master level 9", c, 9 * SLOT_CLKS);
    mstrCfg = 6'h0F;
    repeat (2) @(negedge clk);
    countLow(0, c); chk(c == FRAME, "R6 master level 15", c, FRAME);
    mstrCfg = 6'h00;
    repeat (2) @(negedge clk);
    countLow(0, c); chk(c == 0, "R6 master level 0", c, 0);
  endtask

  task automatic t_wave;
    logic [1:0] pat [4] = '{2'b01, 2'b10, 2'b11, 2'b00};
    setCodes(7'b0000011, 7'b0000011, 7'b0000010);
    for (int k = 0; k < 4; k++) begin
      bankWave = pat[k];
      @(negedge clk);
      chk(ledSink[1:0] == pat[k], "R7 wave follow", ledSink[1:0], pat[k]);
    end
  endtask

  task automatic shot(input logic [1:0] d, input logic [1:0] f);
    @(negedge clk);
    shotDone = d; shotFinalOn = f;
    @(negedge clk);
    shotDone = 2'b00; shotFinalOn = 2'b00;
  endtask

  task automatic t_shot;
    setCodes(7'b0000111, 7'b0001111, 7'b0000010);
    shot(2'b01, 2'b01);
    chk(selQ2 == 8'h02 && selQ1 == 8'h0F && selQ0 == 8'h02, "R8 bank0 final on",
        {selQ2, selQ1, selQ0}, 24'h020F02);
    shot(2'b10, 2'b00);
    chk(selQ2 == 8'h00 && selQ1 == 8'h0D && selQ0 == 8'h02, "R8 bank1 final off",
        {selQ2, selQ1, selQ0}, 24'h000D02);
  endtask

  task automatic t_collide;
    setCodes(7'b0000001, 7'b0000001, 7'b0000000);
    @(negedge clk);
    regWrEn = 1'b1; regWrSel = 2'd2; regWrData = 7'b0000011;
    shotDone = 2'b01; shotFinalOn = 2'b00;
    @(negedge clk);
    regWrEn = 1'b0; shotDone = 2'b00;
    chk(selQ2 == 8'h03, "R9 written reg wins", selQ2, 8'h03);
    chk(selQ1 == 8'h00, "R9 rewrite on other reg", selQ1, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mapping();
    t_off();
    t_gpio();
    t_banks();
    t_override();
    t_master();
    t_wave();
    t_shot();
    t_collide();
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule